// File: doc/BRIEF.md
# Serial Byte Receiver with Even-Parity Check

This block recovers bytes from an asynchronous serial line. The line idles high. A frame is made of one low start bit, eight data bits sent least significant bit first, one parity bit and one high stop bit. The receiver works at a fixed bit period of `CLK_HZ / BAUD_RATE` clock cycles, and the default bit rate is 9600 bits per second. The serial input first passes through a two-flop synchronizer. A down-going level seen while the receiver is idle starts a frame. The receiver confirms the start bit half a bit time later and then samples every later bit near the centre of its period.

After the stop bit has been sampled, the recovered byte is published on `rx_byte` together with a one-cycle `byte_valid` pulse. Two conditions must both hold: the parity bit equals the XOR of the eight data bits (even parity), and the stop bit is high. A frame that fails either condition is dropped without any output. `rx_byte` keeps the last good byte until the next good frame arrives.

The control state machine has four states:
- `RX_IDLE` waits for a low line and moves to `RX_START`.
- `RX_START` waits half a bit. It moves to `RX_DATA` if the line is still low, and otherwise returns to `RX_IDLE`.
- `RX_DATA` shifts in nine bits (the eight data bits, then the parity bit), one per bit period, and moves to `RX_STOP` after the ninth bit.
- `RX_STOP` samples the stop bit, publishes or drops the byte, and returns to `RX_IDLE`.

Top module: `serial_rx_parity`

## Requirements
- R1: While `arst` is high and right after it falls, `rx_byte` is 0 and `byte_valid` is 0.
- R2: A frame is one low start bit, eight data bits least significant bit first, one parity bit and one stop bit. Each bit lasts `CLK_HZ/BAUD_RATE` clock cycles. A well-formed frame yields exactly one `byte_valid` pulse carrying its data byte.
- R3: `byte_valid` rises only when the received parity bit equals the XOR of the eight received data bits. A frame with wrong parity gives no pulse and leaves `rx_byte` unchanged.
- R4: A frame whose stop bit is sampled low gives no pulse and leaves `rx_byte` unchanged.
- R5: A low level on the line that lasts less than half a bit period is not taken as a start bit. No byte is produced, and the next proper frame is received normally.
- R6: `byte_valid` is high for exactly one clock cycle per accepted frame.
- R7: `rx_byte` changes only in the cycle where `byte_valid` is high, and otherwise holds its value.
- R8: Frames sent back to back, with the next start bit immediately after a stop bit, are each received.
- R9: The state machine only follows the transitions IDLE→START, START→DATA, START→IDLE, DATA→STOP and STOP→IDLE, or stays in its current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst | input | 1 | Asynchronous reset, active high |
| ser_in | input | 1 | Serial line, idles high |
| rx_byte | output | 8 | Last byte received with good parity and stop bit |
| byte_valid | output | 1 | One-cycle strobe marking a new byte on `rx_byte` |

## Verification
The bench sends frames with a flipped parity bit and with a low stop bit. A receiver that skipped either check would raise `byte_valid` and overwrite `rx_byte`. A short low glitch probes start-bit confirmation: a receiver without the half-bit recheck would lock onto noise and then misframe the good frame that follows. Back-to-back frames and bytes with the end bits set (0x01, 0x80) catch off-by-one errors in bit count and bit order, and the strobe is watched for any pulse longer than one cycle.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    localparam int RXP_DATA_BITS = 8;
    localparam int RXP_WORD_BITS = RXP_DATA_BITS + 1;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rxp_sync.sv
module rxp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) pipe <= '1;
        else      pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rxp_bit_timer.sv
module rxp_bit_timer #(
    parameter int BIT_CLKS = 16
) (
    input  logic clk,
    input  logic arst,
    input  logic clr,
    output logic half_hit,
    output logic full_hit
);
    localparam int CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);
    localparam logic [CW-1:0] MID  = CW'(BIT_CLKS / 2 - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge arst) begin
        if (arst)     cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign half_hit = (cnt == MID);
    assign full_hit = (cnt == LAST);

    // R2: the bit counter never runs past one bit period
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (arst)
        cnt <= LAST);
endmodule

// File: rtl/rxp_shifter.sv
module rxp_shifter #(
    parameter int WORD_BITS = 9
) (
    input  logic                 clk,
    input  logic                 arst,
    input  logic                 clr,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [WORD_BITS-1:0] word,
    output logic                 last
);
    localparam int IW = $clog2(WORD_BITS + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(WORD_BITS - 1);

    logic [IW-1:0] ndx;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            word <= '0;
            ndx  <= '0;
        end else if (clr) begin
            ndx  <= '0;
        end else if (shift_en) begin
            word <= {bit_in, word[WORD_BITS-1:1]};
            ndx  <= ndx + 1'b1;
        end
    end

    assign last = (ndx == LAST_IDX);

    // R2: never more than the nine framed bits are shifted in
    a_r2_index_bound: assert property (@(posedge clk) disable iff (arst)
        ndx <= IW'(WORD_BITS));
endmodule

// File: rtl/serial_rx_parity.sv
module serial_rx_parity
    import rxp_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int BAUD_RATE = 9600
) (
    input  logic       clk,
    input  logic       arst,
    input  logic       ser_in,
    output logic [7:0] rx_byte,
    output logic       byte_valid
);
    localparam int BIT_CLKS = CLK_HZ / BAUD_RATE;

    rx_state_t state, state_nx;
    logic line, half_hit, full_hit, tmr_clr;
    logic sh_en, sh_clr, sh_last, parity_ok, accept;
    logic [RXP_WORD_BITS-1:0] word;

    rxp_sync #(.STAGES(2)) sync_i (
        .clk(clk), .arst(arst), .din(ser_in), .dout(line)
    );

    rxp_bit_timer #(.BIT_CLKS(BIT_CLKS)) timer_i (
        .clk(clk), .arst(arst), .clr(tmr_clr),
        .half_hit(half_hit), .full_hit(full_hit)
    );

    rxp_shifter #(.WORD_BITS(RXP_WORD_BITS)) shift_i (
        .clk(clk), .arst(arst), .clr(sh_clr), .shift_en(sh_en),
        .bit_in(line), .word(word), .last(sh_last)
    );

    assign sh_en     = (state == RX_DATA) && full_hit;
    assign sh_clr    = (state == RX_IDLE);
    assign parity_ok = ((^word[RXP_DATA_BITS-1:0]) == word[RXP_DATA_BITS]);
    assign accept    = (state == RX_STOP) && full_hit && line && parity_ok;

    always_comb begin
        state_nx = state;
        tmr_clr  = 1'b0;
        unique case (state)
            RX_IDLE: begin
                tmr_clr = 1'b1;
                if (!line) state_nx = RX_START;
            end
            RX_START: begin
                tmr_clr = half_hit;
                if (half_hit) state_nx = line ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                tmr_clr = full_hit;
                if (full_hit && sh_last) state_nx = RX_STOP;
            end
            RX_STOP: begin
                tmr_clr = full_hit;
                if (full_hit) state_nx = RX_IDLE;
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) state <= RX_IDLE;
        else      state <= state_nx;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            rx_byte    <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= accept;
            if (accept) rx_byte <= word[RXP_DATA_BITS-1:0];
        end
    end

    // R6: the strobe never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (arst)
        byte_valid |=> !byte_valid);
    // R7: the byte output is held when no strobe is given
    a_r7_hold: assert property (@(posedge clk) disable iff (arst)
        !byte_valid |-> $stable(rx_byte));
    // R3: a published byte agrees with the parity bit it came with
    a_r3_parity: assert property (@(posedge clk) disable iff (arst)
        byte_valid |-> ((^rx_byte) == word[RXP_DATA_BITS]));
    // R4: a strobe follows only a high stop sample in the stop phase
    a_r4_stop_high: assert property (@(posedge clk) disable iff (arst)
        byte_valid |-> ($past(state) == RX_STOP && $past(line)));
    // R9: legal transitions only
    a_r9_from_idle: assert property (@(posedge clk) disable iff (arst)
        state == RX_IDLE |=> state inside {RX_IDLE, RX_START});
    a_r9_from_start: assert property (@(posedge clk) disable iff (arst)
        state == RX_START |=> state inside {RX_START, RX_DATA, RX_IDLE});
    a_r9_from_data: assert property (@(posedge clk) disable iff (arst)
        state == RX_DATA |=> state inside {RX_DATA, RX_STOP});
    a_r9_from_stop: assert property (@(posedge clk) disable iff (arst)
        state == RX_STOP |=> state inside {RX_STOP, RX_IDLE});
endmodule

// File: tb/serial_rx_parity_tb.sv
module serial_rx_parity_tb_top;
    localparam int CLK_HZ = 200_000_000;
    localparam int BAUD   = 12_500_000;
    localparam int BIT    = CLK_HZ / BAUD;   // 16 clocks per bit

    logic       clk = 1'b0;
    logic       arst = 1'b1;
    logic       ser_in = 1'b1;
    logic [7:0] rx_byte;
    logic       byte_valid;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int run = 0;
    int max_run = 0;
    logic [7:0] cap [0:3];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_rx_parity #(.CLK_HZ(CLK_HZ), .BAUD_RATE(BAUD)) dut_i (
        .clk(clk), .arst(arst), .ser_in(ser_in),
        .rx_byte(rx_byte), .byte_valid(byte_valid)
    );

    always @(negedge clk) begin
        if (byte_valid) begin
            if (pulses < 4) cap[pulses] = rx_byte;
            pulses = pulses + 1;
            run = run + 1;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        ser_in = v;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit flip_par, input logic stop_v);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        hold_bit((^b) ^ flip_par);
        hold_bit(stop_v);
        ser_in = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 byte during reset", rx_byte, 0);
        check("R1 valid during reset", byte_valid, 0);
        arst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 byte after reset", rx_byte, 0);
        check("R1 valid after reset", byte_valid, 0);
    endtask

    task automatic t_good(input logic [7:0] b);
        pulses = 0;
        send_frame(b, 1'b0, 1'b1);
        repeat (2 * BIT) @(negedge clk);
        check("R2 R9 one pulse per frame", pulses, 1);
        check("R2 byte value", cap[0], b);
        check("R2 byte held", rx_byte, b);
    endtask

    task automatic t_bad_parity(input logic [7:0] b, input logic [7:0] prev);
        pulses = 0;
        send_frame(b, 1'b1, 1'b1);
        repeat (2 * BIT) @(negedge clk);
        check("R3 no pulse on bad parity", pulses, 0);
        check("R3 R7 byte unchanged", rx_byte, prev);
    endtask

    task automatic t_bad_stop(input logic [7:0] b, input logic [7:0] prev);
        pulses = 0;
        send_frame(b, 1'b0, 1'b0);
        repeat (3 * BIT) @(negedge clk);
        check("R4 no pulse on low stop", pulses, 0);
        check("R4 byte unchanged", rx_byte, prev);
    endtask

    task automatic t_glitch(input logic [7:0] b);
        pulses = 0;
        ser_in = 1'b0;
        repeat (BIT / 4) @(negedge clk);
        ser_in = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        check("R5 glitch ignored", pulses, 0);
        send_frame(b, 1'b0, 1'b1);
        repeat (2 * BIT) @(negedge clk);
        check("R5 frame after glitch", pulses, 1);
        check("R5 byte after glitch", rx_byte, b);
    endtask

    task automatic t_back_to_back(input logic [7:0] a, input logic [7:0] b);
        pulses = 0;
        send_frame(a, 1'b0, 1'b1);
        send_frame(b, 1'b0, 1'b1);
        repeat (2 * BIT) @(negedge clk);
        check("R8 two pulses", pulses, 2);
        check("R8 first byte", cap[0], a);
        check("R8 second byte", cap[1], b);
    endtask

    initial begin
        repeat (100_000) @(negedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        repeat (2 * BIT) @(negedge clk);
        t_good(8'hA5);
        t_good(8'h01);
        t_good(8'h80);
        t_good(8'hFF);
        t_good(8'h3C);
        t_bad_parity(8'h5A, 8'h3C);
        t_bad_parity(8'h00, 8'h3C);
        t_bad_stop(8'h77, 8'h3C);
        t_good(8'h00);
        t_glitch(8'hC3);
        t_back_to_back(8'h12, 8'hED);
        check("R6 strobe width", max_run, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule